// File: doc/BRIEF.md
# Pseudo-Random Noise Waveform Generator

This block produces the one-bit pseudo-random waveform that gates the amplitude of a noise sound channel. A 15-bit shift register with XOR feedback is advanced by a frequency timer. The timer is loaded from a period, and the period is built from a small non-linear divisor table shifted left by a programmable amount. On every system tick the timer loses four counts. A short mode also writes the feedback into bit 6, so the output repeats every 127 steps instead of every 32767.

Software programs the generator through one 8-bit control register, which reads back unchanged, and starts a note with a trigger pulse. The trigger reseeds the register and restarts the timer. A write to the control register leaves a running count alone. The new period only takes effect at the next reload or trigger.

The timer runs as a two-state machine. `TMR_EMPTY` is the reset state, in which no period has been loaded yet. `TMR_RUN` means the timer holds a live count. The machine moves from EMPTY to RUN on its first tick (transition LOAD) or on a trigger (transition RESTART). In RUN, a tick either subtracts four (transition COUNT) or reloads the period and advances the shift register (transition RELOAD). A trigger in RUN takes RESTART. Reset returns the machine to EMPTY.

Top module: `noise_wave_gen`

## Requirements
- R1: The period equals the divisor, shifted left by the clock shift value (control bits 7:4). The divisor is chosen by the code in control bits 2:0: code 0 gives 8 and code c (1 to 7) gives 16·c.
- R2: On a tick with no trigger, an unloaded timer (state EMPTY, value 0) first takes the period. If the resulting value is above 4 it drops by 4. Otherwise it reloads the period and the shift register advances once. After any tick or trigger the timer is never 0.
- R3: In a cycle with neither a tick nor a trigger, the timer and the shift register hold their values.
- R4: On each advance, the new value is the register shifted right by one, with bit 0 XOR bit 1 of the old value written into bit 14.
- R5: When control bit 3 is 1 (short mode), an advance also writes the feedback bit into bit 6. When bit 3 is 0, bit 6 takes old bit 7.
- R6: A trigger loads the register with 0x7FFF and loads the timer with the period of the current control value. A trigger in the same cycle as a tick wins, and the tick has no effect.
- R7: `noise_o` is 1 when register bit 0 is 0, and 0 when it is 1.
- R8: A control write stores all 8 bits, and `cfg_rdata_o` shows them from the next cycle.
- R9: A control write does not change a timer that is already counting. The new period is used from the next reload or trigger.
- R10: After reset the register is 0x7FFF, the timer is 0 in state EMPTY, the control value is 0, and `noise_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_i | input | 1 | Timer tick; the timer decrements by 4 |
| trig_i | input | 1 | Reseed the register and restart the timer |
| cfg_we_i | input | 1 | Control register write strobe |
| cfg_wdata_i | input | 8 | Control write data: shift[7:4], short mode[3], code[2:0] |
| cfg_rdata_o | output | 8 | Control register read data |
| noise_o | output | 1 | Noise level; high when register bit 0 is 0 |

## Verification
The bench sweeps every divisor code, shift values 0 and 1, both widths, and several tick patterns. It compares the output with an arithmetic model on every cycle. A wrong table entry, a decrement other than four, or a reload off by one count would shift the output in time. A wrong short-mode tap would leave the 15-bit sequence unchanged but corrupt the 127-step one.

Separate cases cover the following:
- Ticking straight after reset, when the timer is still empty. A design that skipped the first load would step at once.
- A trigger in the same cycle as a tick. A design that let the tick through would advance the register one step too early.
- A control write in the middle of a long count. A design that reloaded the timer at once would advance the register far too soon.
- Idle stretches and a sweep of every control value through read-back.

// File: rtl/noise_pkg.sv
package noise_pkg;
    localparam int SHIFT_W   = 4;
    localparam int CODE_W    = 3;
    localparam int CFG_W     = SHIFT_W + 1 + CODE_W;
    localparam int LFSR_W    = 15;
    localparam int SHORT_BIT = 6;
    localparam int DEC_STEP  = 4;
    localparam int DIV_W     = CODE_W + 4;
    localparam int TMR_W     = DIV_W + (1 << SHIFT_W) - 1;

    typedef enum logic {
        TMR_EMPTY = 1'b0,
        TMR_RUN   = 1'b1
    } tmr_state_e;

    typedef struct packed {
        logic [SHIFT_W-1:0] shift;
        logic               short_mode;
        logic [CODE_W-1:0]  code;
    } noise_cfg_t;

    function automatic logic [DIV_W-1:0] divisor_of(input logic [CODE_W-1:0] c);
        if (c == '0) return DIV_W'(8);
        return {c, 4'b0000};
    endfunction
endpackage

// File: rtl/noise_cfg_reg.sv
module noise_cfg_reg
    import noise_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we_i,
    input  logic [CFG_W-1:0] wdata_i,
    output noise_cfg_t       cfg_o
);
    noise_cfg_t cfg_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else if (we_i) begin
            cfg_q <= noise_cfg_t'(wdata_i);
        end
    end

    assign cfg_o = cfg_q;
endmodule

// File: rtl/noise_period.sv
module noise_period
    import noise_pkg::*;
(
    input  noise_cfg_t       cfg_i,
    output logic [TMR_W-1:0] period_o
);
    always_comb begin
        period_o = TMR_W'(divisor_of(cfg_i.code)) << cfg_i.shift;
    end
endmodule

// File: rtl/noise_timer.sv
module noise_timer
    import noise_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic             trig_i,
    input  logic [TMR_W-1:0] period_i,
    output logic             step_o,
    output logic [TMR_W-1:0] timer_o
);
    tmr_state_e       state_q, state_d;
    logic [TMR_W-1:0] timer_q, timer_d;
    logic [TMR_W-1:0] cur;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= TMR_EMPTY;
            timer_q <= '0;
        end else begin
            state_q <= state_d;
            timer_q <= timer_d;
        end
    end

    // next state and outputs
    always_comb begin
        state_d = state_q;
        timer_d = timer_q;
        step_o  = 1'b0;
        cur     = timer_q;
        if (trig_i) begin
            timer_d = period_i;
            state_d = TMR_RUN;
        end else if (tick_i) begin
            unique case (state_q)
                TMR_EMPTY: cur = period_i;
                TMR_RUN:   cur = timer_q;
                default:   cur = period_i;
            endcase
            if (cur > TMR_W'(DEC_STEP)) begin
                timer_d = cur - TMR_W'(DEC_STEP);
            end else begin
                timer_d = period_i;
                step_o  = 1'b1;
            end
            state_d = TMR_RUN;
        end
    end

    assign timer_o = timer_q;
endmodule

// File: rtl/noise_lfsr.sv
module noise_lfsr
    import noise_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic              step_i,
    input  logic              short_i,
    output logic [LFSR_W-1:0] lfsr_o
);
    logic [LFSR_W-1:0] q, nxt;
    logic              fb;

    always_comb begin
        fb  = q[0] ^ q[1];
        nxt = {fb, q[LFSR_W-1:1]};
        if (short_i) nxt[SHORT_BIT] = fb;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '1;
        end else if (load_i) begin
            q <= '1;
        end else if (step_i) begin
            q <= nxt;
        end
    end

    assign lfsr_o = q;
endmodule

// File: rtl/noise_wave_gen.sv
module noise_wave_gen
    import noise_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick_i,
    input  logic       trig_i,
    input  logic       cfg_we_i,
    input  logic [7:0] cfg_wdata_i,
    output logic [7:0] cfg_rdata_o,
    output logic       noise_o
);
    noise_cfg_t        cfg_q;
    logic [TMR_W-1:0]  period_w;
    logic [TMR_W-1:0]  timer_q;
    logic              step_w;
    logic [LFSR_W-1:0] lfsr_q;

    noise_cfg_reg u_cfg (
        .clk    (clk),
        .rst_n  (rst_n),
        .we_i   (cfg_we_i),
        .wdata_i(cfg_wdata_i),
        .cfg_o  (cfg_q)
    );

    noise_period u_per (
        .cfg_i   (cfg_q),
        .period_o(period_w)
    );

    noise_timer u_tmr (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick_i  (tick_i),
        .trig_i  (trig_i),
        .period_i(period_w),
        .step_o  (step_w),
        .timer_o (timer_q)
    );

    noise_lfsr u_lfsr (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (trig_i),
        .step_i (step_w),
        .short_i(cfg_q.short_mode),
        .lfsr_o (lfsr_q)
    );

    assign cfg_rdata_o = cfg_q;
    assign noise_o     = ~lfsr_q[0];
endmodule

// File: rtl/noise_wave_chk.sv
module noise_wave_chk
    import noise_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              tick_i,
    input logic              trig_i,
    input logic              cfg_we_i,
    input logic [7:0]        cfg_wdata_i,
    input logic [7:0]        cfg_rdata_o,
    input logic [LFSR_W-1:0] lfsr,
    input logic [TMR_W-1:0]  timer,
    input logic              step
);
    // R6
    seed_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trig_i |=> (lfsr == {LFSR_W{1'b1}}));

    // R8
    cfg_readback_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we_i |=> (cfg_rdata_o == $past(cfg_wdata_i)));

    // R2
    timer_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i || trig_i) |=> (timer != '0));

    // R3
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_i && !trig_i) |=> ($stable(lfsr) && $stable(timer)));

    // R4
    shift_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !trig_i) |=> ((lfsr[LFSR_W-2:SHORT_BIT+1] == $past(lfsr[LFSR_W-1:SHORT_BIT+2]))
                              && (lfsr[SHORT_BIT-1:0] == $past(lfsr[SHORT_BIT:1]))));

    // R4
    feedback_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !trig_i) |=> (lfsr[LFSR_W-1] == ($past(lfsr[0]) ^ $past(lfsr[1]))));
endmodule

bind noise_wave_gen noise_wave_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick_i     (tick_i),
    .trig_i     (trig_i),
    .cfg_we_i   (cfg_we_i),
    .cfg_wdata_i(cfg_wdata_i),
    .cfg_rdata_o(cfg_rdata_o),
    .lfsr       (lfsr_q),
    .timer      (timer_q),
    .step       (step_w)
);

// File: tb/sim_noise_wave_gen.sv
`timescale 1ns/1ps
module sim_noise_wave_gen;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_i = 1'b0;
    logic       trig_i = 1'b0;
    logic       cfg_we_i = 1'b0;
    logic [7:0] cfg_wdata_i = 8'h00;
    logic [7:0] cfg_rdata_o;
    logic       noise_o;

    int n_chk = 0;
    int n_fail = 0;
    string cur_req = "R10";

    // model state
    logic [14:0] m_lfsr = 15'h7FFF;
    longint      m_tmr = 0;
    logic [7:0]  m_cfg = 8'h00;

    always #2.5 clk = ~clk;

    noise_wave_gen u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick_i     (tick_i),
        .trig_i     (trig_i),
        .cfg_we_i   (cfg_we_i),
        .cfg_wdata_i(cfg_wdata_i),
        .cfg_rdata_o(cfg_rdata_o),
        .noise_o    (noise_o)
    );

    function automatic longint m_period(input logic [7:0] c);
        longint d;
        d = (c[2:0] == 3'd0) ? 8 : 16 * c[2:0];
        return d << c[7:4];
    endfunction

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic cycle(input bit tk, input bit tg, input bit we, input logic [7:0] wd);
        longint cur;
        logic   fb;
        tick_i = tk; trig_i = tg; cfg_we_i = we; cfg_wdata_i = wd;
        @(posedge clk);
        if (tg) begin
            m_lfsr = 15'h7FFF;
            m_tmr  = m_period(m_cfg);
        end else if (tk) begin
            cur = (m_tmr == 0) ? m_period(m_cfg) : m_tmr;
            if (cur > 4) m_tmr = cur - 4;
            else begin
                m_tmr = m_period(m_cfg);
                fb = m_lfsr[0] ^ m_lfsr[1];
                m_lfsr = {fb, m_lfsr[14:1]};
                if (m_cfg[3]) m_lfsr[6] = fb;
            end
        end
        if (we) m_cfg = wd;
        @(negedge clk);
        tick_i = 1'b0; trig_i = 1'b0; cfg_we_i = 1'b0;
        check(noise_o == ~m_lfsr[0], cur_req, noise_o, ~m_lfsr[0]);
    endtask

    initial begin
        #(200000 * 5);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R10 reset state
        check(noise_o == 1'b0, "R10", noise_o, 0);
        check(cfg_rdata_o == 8'h00, "R10", cfg_rdata_o, 0);

        // R2 tick from empty timer, R7 polarity along the way
        cur_req = "R2";
        for (int i = 0; i < 60; i++) cycle(1'b1, 1'b0, 1'b0, 8'h00);

        // R8 read-back sweep of every control value
        for (int v = 0; v < 256; v++) begin
            cycle(1'b0, 1'b0, 1'b1, 8'(v));
            check(cfg_rdata_o == 8'(v), "R8", cfg_rdata_o, v);
        end

        // R1 R4 R5 R7 sweep: modes, shifts, codes, tick patterns
        for (int md = 0; md < 2; md++) begin
            for (int sh = 0; sh < 2; sh++) begin
                for (int cd = 0; cd < 8; cd++) begin
                    logic [7:0] cv;
                    cv = {4'(sh), 1'(md), 3'(cd)};
                    cur_req = md ? "R5" : "R1";
                    cycle(1'b0, 1'b0, 1'b1, cv);
                    cycle(1'b0, 1'b1, 1'b0, 8'h00);
                    cur_req = md ? "R5" : "R4";
                    for (int i = 0; i < 260; i++)
                        cycle(((i % 3) != 2) || (cd[0] == 1'b0), 1'b0, 1'b0, 8'h00);
                end
            end
        end

        // R6 trigger together with tick
        cur_req = "R6";
        cycle(1'b0, 1'b0, 1'b1, 8'h00);
        for (int i = 0; i < 37; i++) cycle(1'b1, 1'b0, 1'b0, 8'h00);
        cycle(1'b1, 1'b1, 1'b0, 8'h00);
        check(noise_o == 1'b0, "R6", noise_o, 0);
        for (int i = 0; i < 40; i++) cycle(1'b1, 1'b0, 1'b0, 8'h00);

        // R9 control write during a long count
        cur_req = "R9";
        cycle(1'b0, 1'b0, 1'b1, 8'h27);
        cycle(1'b0, 1'b1, 1'b0, 8'h00);
        for (int i = 0; i < 50; i++) cycle(1'b1, 1'b0, 1'b0, 8'h00);
        cycle(1'b1, 1'b0, 1'b1, 8'h08);
        for (int i = 0; i < 400; i++) cycle(1'b1, 1'b0, 1'b0, 8'h00);

        // R3 idle cycles hold state
        cur_req = "R3";
        for (int i = 0; i < 30; i++) cycle(1'b0, 1'b0, 1'b0, 8'h00);
        for (int i = 0; i < 20; i++) cycle(1'b1, 1'b0, 1'b0, 8'h00);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule